// File: doc/BRIEF.md
# Windowed Layer Alpha Blender

This block mixes a single layer pixel over a solid background colour for every display position it is handed. The layer shows only inside a rectangle whose corners are given in accumulated timing coordinates, meaning the counts that include sync width and back porch, not the visible-area indices. A position inside the rectangle is one more than the active-area coordinate plus the accumulated back porch, and both edges of the rectangle are inclusive. Outside that rectangle, or with the layer switched off, the background colour passes through untouched.

Two 3-bit selectors choose the weight of the layer and the weight of the background. The layer weight is either the constant alpha alone or the pixel alpha scaled by the constant alpha. The background weight is either one minus the constant alpha or one minus that scaled product. Alpha values are 8-bit fractions where 255 stands for 1.0. Each colour channel is the weighted sum divided by 255, rounded to nearest and clamped at 255. The datapath is a fixed two-stage pipeline with a matching valid flag. Unpacking of other pixel formats and memory fetch happen elsewhere.

Top module: `layer_window_blender`

## Requirements
- R1: The horizontal window word holds the start position in bits 11:0 and the stop position in bits 27:16. A column x is inside when start <= x <= stop, both bounds inclusive. A start above the stop gives an empty window.
- R2: The vertical window word holds the start row in bits 10:0 and the stop row in bits 26:16. A row y is inside when start <= y <= stop, both bounds inclusive.
- R3: With the layer enable low, the output equals the background colour at every position.
- R4: Outside the window the output equals the background colour unchanged. Both the background input and the output use red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: The layer weight selector sits in bits 10:8 of the blend configuration word. Code 4 makes the layer weight equal the constant alpha. Code 6 makes it round(pixel alpha x constant alpha / 255), where pixel alpha is bits 31:24 of the layer pixel.
- R6: The background weight selector sits in bits 2:0 of the blend configuration word. Code 5 makes the background weight 255 minus the constant alpha. Code 7 makes it 255 minus the rounded product of R5.
- R7: Any layer weight code other than 4 acts as code 6. Any background weight code other than 5 acts as code 7.
- R8: Inside the window with the layer enabled, each channel equals round((layer weight x layer channel + background weight x background channel) / 255), clamped to 255. The layer pixel carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R9: The result and out_valid appear two clock edges after the inputs are sampled. out_valid copies in_valid with that delay and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input position and pixels are valid |
| pos_x | input | 12 | Current column in accumulated timing coordinates |
| pos_y | input | 11 | Current row in accumulated timing coordinates |
| layer_argb | input | 32 | Layer pixel, alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| bg_rgb | input | 24 | Background colour, red 23:16, green 15:8, blue 7:0 |
| const_alpha | input | 8 | Constant alpha, 255 means 1.0 |
| blend_cfg | input | 11 | Layer weight code in 10:8, background weight code in 2:0 |
| win_h | input | 32 | Horizontal window, start 11:0, stop 27:16 |
| win_v | input | 32 | Vertical window, start 10:0, stop 26:16 |
| layer_en | input | 1 | Layer enable |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Blended pixel, red 23:16, green 15:8, blue 7:0 |

## Verification
Directed positions just before, on and just after each window edge separate an inclusive compare from an exclusive or off-by-one one, on both axes. Matched selector pairs (4 with 5, 6 with 7) with mid-range alphas tell the constant and product weights apart, while unused codes and a mixed pair such as 4 with 7 show the fallback and the clamp at 255. A random mix of positions, small windows, alphas, colours and codes, with gaps in in_valid, checks the rounding and the two-cycle alignment of data and valid against a reference model.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    localparam int CH_W   = 8;
    localparam int CH_MAX = 255;
    localparam int ACC_W  = 2 * CH_W + 1;

    typedef enum logic [2:0] {
        LW_CONST = 3'd4,
        LW_PROD  = 3'd6
    } layer_wt_e;

    typedef enum logic [2:0] {
        BW_INV_CONST = 3'd5,
        BW_INV_PROD  = 3'd7
    } back_wt_e;

    function automatic logic [ACC_W-1:0] div_round_255(input logic [ACC_W-1:0] v);
        logic [ACC_W-1:0] biased;
        biased = v + ACC_W'(127);
        return biased / ACC_W'(CH_MAX);
    endfunction

endpackage

// File: rtl/lwb_window.sv
module lwb_window #(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    input  logic [31:0]   win_h,
    input  logic [31:0]   win_v,
    input  logic          layer_en,
    output logic          hit
);
    localparam int STOP_LSB = 16;

    logic [XW-1:0] h_first, h_last;
    logic [YW-1:0] v_first, v_last;
    logic          in_cols, in_rows;
    logic          unused_fields;

    assign h_first = win_h[XW-1:0];
    assign h_last  = win_h[STOP_LSB +: XW];
    assign v_first = win_v[YW-1:0];
    assign v_last  = win_v[STOP_LSB +: YW];
    assign unused_fields = ^{win_h, win_v};

    assign in_cols = (pos_x >= h_first) && (pos_x <= h_last);
    assign in_rows = (pos_y >= v_first) && (pos_y <= v_last);
    assign hit     = layer_en && in_cols && in_rows;

    // R1: a reversed horizontal window never admits the layer
    always_comb begin
        if (h_first > h_last)
            assert_empty_window_R1: assert (!hit);
    end

endmodule

// File: rtl/lwb_factor.sv
module lwb_factor
    import lwb_pkg::*;
(
    input  logic [CH_W-1:0] pix_alpha,
    input  logic [CH_W-1:0] const_alpha,
    input  logic [2:0]      layer_code,
    input  logic [2:0]      back_code,
    output logic [CH_W-1:0] layer_wt,
    output logic [CH_W-1:0] back_wt
);
    logic [ACC_W-1:0] raw_prod;
    logic [ACC_W-1:0] norm_prod;
    logic [CH_W-1:0]  prod8;

    assign raw_prod  = ACC_W'({{CH_W{1'b0}}, pix_alpha} * {{CH_W{1'b0}}, const_alpha});
    assign norm_prod = div_round_255(raw_prod);
    assign prod8     = norm_prod[CH_W-1:0];

    always_comb begin
        unique case (layer_code)
            LW_CONST: layer_wt = const_alpha;
            default:  layer_wt = prod8;
        endcase
        unique case (back_code)
            BW_INV_CONST: back_wt = CH_W'(CH_MAX) - const_alpha;
            default:      back_wt = CH_W'(CH_MAX) - prod8;
        endcase
    end

    // R6: matched selector pairs always weigh to exactly one
    always_comb begin
        if ((layer_code == 3'd4 && back_code == 3'd5) ||
            (layer_code == 3'd6 && back_code == 3'd7))
            assert_pair_unity_R6: assert ((9'(layer_wt) + 9'(back_wt)) == 9'd255);
    end

    // R5: a constant alpha of 1.0 leaves the pixel alpha unchanged
    always_comb begin
        if (const_alpha == 8'hFF && layer_code == 3'd6)
            assert_full_const_R5: assert (layer_wt == pix_alpha);
    end

endmodule

// File: rtl/lwb_channel.sv
module lwb_channel
    import lwb_pkg::*;
(
    input  logic [CH_W-1:0] layer_c,
    input  logic [CH_W-1:0] back_c,
    input  logic [CH_W-1:0] layer_wt,
    input  logic [CH_W-1:0] back_wt,
    output logic [CH_W-1:0] mixed
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] quot;

    assign acc  = ACC_W'(layer_wt * layer_c) + ACC_W'(back_wt * back_c);
    assign quot = div_round_255(acc);
    assign mixed = (quot > ACC_W'(CH_MAX)) ? CH_W'(CH_MAX) : quot[CH_W-1:0];

    // R8: full layer weight with zero background weight reproduces the layer
    always_comb begin
        if (layer_wt == 8'hFF && back_wt == 8'h00)
            assert_layer_identity_R8: assert (mixed == layer_c);
    end

endmodule

// File: rtl/layer_window_blender.sv
module layer_window_blender
    import lwb_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    input  logic [31:0]   layer_argb,
    input  logic [23:0]   bg_rgb,
    input  logic [7:0]    const_alpha,
    input  logic [10:0]   blend_cfg,
    input  logic [31:0]   win_h,
    input  logic [31:0]   win_v,
    input  logic          layer_en,
    output logic          out_valid,
    output logic [23:0]   out_rgb
);
    localparam int NCH   = 3;
    localparam int RGB_W = NCH * CH_W;

    logic            hit_c;
    logic [CH_W-1:0] lw_c, bw_c;
    logic            unused_cfg;

    // stage 1 registers
    logic             s1_valid;
    logic             s1_hit;
    logic [RGB_W-1:0] s1_layer;
    logic [RGB_W-1:0] s1_bg;
    logic [CH_W-1:0]  s1_lw, s1_bw;

    logic [RGB_W-1:0] mix_c;

    assign unused_cfg = ^blend_cfg[7:3];

    lwb_window #(.XW(XW), .YW(YW)) u_window (
        .pos_x    (pos_x),
        .pos_y    (pos_y),
        .win_h    (win_h),
        .win_v    (win_v),
        .layer_en (layer_en),
        .hit      (hit_c)
    );

    lwb_factor u_factor (
        .pix_alpha   (layer_argb[31:24]),
        .const_alpha (const_alpha),
        .layer_code  (blend_cfg[10:8]),
        .back_code   (blend_cfg[2:0]),
        .layer_wt    (lw_c),
        .back_wt     (bw_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_layer <= '0;
            s1_bg    <= '0;
            s1_lw    <= '0;
            s1_bw    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_hit   <= hit_c;
            s1_layer <= layer_argb[RGB_W-1:0];
            s1_bg    <= bg_rgb;
            s1_lw    <= lw_c;
            s1_bw    <= bw_c;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        lwb_channel u_chan (
            .layer_c  (s1_layer[g*CH_W +: CH_W]),
            .back_c   (s1_bg[g*CH_W +: CH_W]),
            .layer_wt (s1_lw),
            .back_wt  (s1_bw),
            .mixed    (mix_c[g*CH_W +: CH_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_rgb   <= s1_hit ? mix_c : s1_bg;
        end
    end

    // R9: each stage's valid descends from the previous stage one edge earlier
    assert_stage1_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(in_valid));
    assert_out_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));

    // R4: a miss forwards the staged background unchanged
    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_hit) |=> (out_rgb == $past(s1_bg)));

endmodule

// File: tb/layer_window_blender_tb_top.sv
module layer_window_blender_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] pos_x = '0;
    logic [10:0] pos_y = '0;
    logic [31:0] layer_argb = '0;
    logic [23:0] bg_rgb = '0;
    logic [7:0]  const_alpha = '0;
    logic [10:0] blend_cfg = '0;
    logic [31:0] win_h = '0;
    logic [31:0] win_v = '0;
    logic        layer_en = 1'b0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expected values two and one applications back
    bit    ev0 = 0, ev1 = 0;
    logic [23:0] ep0 = '0, ep1 = '0;
    string et0 = "R9", et1 = "R9";

    always #5 clk = ~clk;

    layer_window_blender dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos_x(pos_x), .pos_y(pos_y),
        .layer_argb(layer_argb), .bg_rgb(bg_rgb), .const_alpha(const_alpha),
        .blend_cfg(blend_cfg), .win_h(win_h), .win_v(win_v), .layer_en(layer_en),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic int rnd255(input int v);
        return (v + 127) / 255;
    endfunction

    function automatic logic [23:0] model(input int x, input int y, input logic [31:0] px,
                                          input logic [23:0] bg, input int ca, input int c1,
                                          input int c2, input logic [31:0] wh,
                                          input logic [31:0] wv, input bit en);
        int hs, hp, vs, vp, pa, prod, f1, f2, ch;
        logic [23:0] r;
        hs = int'(wh[11:0]);  hp = int'(wh[27:16]);
        vs = int'(wv[10:0]);  vp = int'(wv[26:16]);
        if (!en || x < hs || x > hp || y < vs || y > vp) return bg;
        pa = int'(px[31:24]);
        prod = rnd255(pa * ca);
        f1 = (c1 == 4) ? ca : prod;
        f2 = (c2 == 5) ? 255 - ca : 255 - prod;
        for (int k = 0; k < 3; k++) begin
            ch = rnd255(f1 * int'(px[k*8 +: 8]) + f2 * int'(bg[k*8 +: 8]));
            if (ch > 255) ch = 255;
            r[k*8 +: 8] = 8'(ch);
        end
        return r;
    endfunction

    task automatic cycle(input bit v, input int x, input int y, input logic [31:0] px,
                         input logic [23:0] bg, input int ca, input int c1, input int c2,
                         input logic [31:0] wh, input logic [31:0] wv, input bit en,
                         input string tag);
        @(negedge clk);
        total++;
        if (out_valid !== ev1) begin
            bad++;
            $display("FAIL %s valid: actual=%0b expected=%0b", et1, out_valid, ev1);
        end
        if (ev1) begin
            total++;
            if (out_rgb !== ep1) begin
                bad++;
                $display("FAIL %s pixel: actual=%06h expected=%06h", et1, out_rgb, ep1);
            end
        end
        ev1 = ev0; ep1 = ep0; et1 = et0;
        ev0 = v;
        ep0 = model(x, y, px, bg, ca, c1, c2, wh, wv, en);
        et0 = tag;
        in_valid = v; pos_x = 12'(x); pos_y = 11'(y); layer_argb = px; bg_rgb = bg;
        const_alpha = 8'(ca); blend_cfg = {3'(c1), 5'd0, 3'(c2)};
        win_h = wh; win_v = wv; layer_en = en;
    endtask

    function automatic logic [31:0] wword(input int first, input int last);
        return (32'(last) << 16) | 32'(first);
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] wh, wv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // reset state: valid low while and right after reset (R9)
        total++;
        if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
            bad++;
            $display("FAIL R9 reset: actual=%0b/%06h expected=0/000000", out_valid, out_rgb);
        end
        rst_n = 1'b1;
        wh = wword(10, 20);
        wv = wword(5, 8);
        // R1 horizontal edges, inclusive
        cycle(1, 9,  6, 32'h80_C0_40_20, 24'h10_20_30, 200, 6, 7, wh, wv, 1, "R1");
        cycle(1, 10, 6, 32'h80_C0_40_20, 24'h10_20_30, 200, 6, 7, wh, wv, 1, "R1");
        cycle(1, 20, 6, 32'h80_C0_40_20, 24'h10_20_30, 200, 6, 7, wh, wv, 1, "R1");
        cycle(1, 21, 6, 32'h80_C0_40_20, 24'h10_20_30, 200, 6, 7, wh, wv, 1, "R1");
        cycle(1, 15, 6, 32'hFF_C0_40_20, 24'h10_20_30, 255, 6, 7, wword(30, 12), wv, 1, "R1");
        // R2 vertical edges, inclusive
        cycle(1, 15, 4, 32'hFF_AA_BB_CC, 24'h11_22_33, 255, 6, 7, wh, wv, 1, "R2");
        cycle(1, 15, 5, 32'hFF_AA_BB_CC, 24'h11_22_33, 255, 6, 7, wh, wv, 1, "R2");
        cycle(1, 15, 8, 32'hFF_AA_BB_CC, 24'h11_22_33, 255, 6, 7, wh, wv, 1, "R2");
        cycle(1, 15, 9, 32'hFF_AA_BB_CC, 24'h11_22_33, 255, 6, 7, wh, wv, 1, "R2");
        // R3 layer disabled inside window
        cycle(1, 15, 6, 32'hFF_AA_BB_CC, 24'h12_34_56, 255, 6, 7, wh, wv, 0, "R3");
        // R4 outside window, distinct channel bytes
        cycle(1, 100, 100, 32'hFF_FF_FF_FF, 24'hA1_B2_C3, 255, 4, 5, wh, wv, 1, "R4");
        // R5/R6 constant pair and product pair
        cycle(1, 12, 7, 32'h40_F0_80_10, 24'h20_60_E0, 128, 4, 5, wh, wv, 1, "R5");
        cycle(1, 12, 7, 32'h40_F0_80_10, 24'h20_60_E0, 128, 6, 7, wh, wv, 1, "R6");
        cycle(1, 12, 7, 32'h9C_F0_80_10, 24'h20_60_E0, 77,  6, 5, wh, wv, 1, "R6");
        // R7 unused codes fall back to the product pair
        cycle(1, 12, 7, 32'h40_F0_80_10, 24'h20_60_E0, 128, 1, 3, wh, wv, 1, "R7");
        cycle(1, 12, 7, 32'h40_F0_80_10, 24'h20_60_E0, 128, 0, 0, wh, wv, 1, "R7");
        // R8 saturation with a mixed pair
        cycle(1, 12, 7, 32'h00_C8_FF_90, 24'h90_FF_C8, 255, 4, 7, wh, wv, 1, "R8");
        // R9 gaps in valid
        cycle(0, 12, 7, 32'hFF_01_02_03, 24'h0, 255, 6, 7, wh, wv, 1, "R9");
        cycle(1, 12, 7, 32'hFF_01_02_03, 24'h0, 255, 6, 7, wh, wv, 1, "R9");
        cycle(0, 12, 7, 32'hFF_04_05_06, 24'h0, 255, 6, 7, wh, wv, 1, "R9");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int a, b, c, d;
            a = int'($urandom_range(0, 40)); b = int'($urandom_range(0, 40));
            c = int'($urandom_range(0, 30)); d = int'($urandom_range(0, 30));
            cycle(bit'($urandom_range(0, 3) != 0),
                  int'($urandom_range(0, 40)), int'($urandom_range(0, 30)),
                  $urandom, 24'($urandom), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                  wword(a, b), wword(c, d), bit'($urandom_range(0, 7) != 0), "R8");
        end
        cycle(0, 0, 0, 32'h0, 24'h0, 0, 6, 7, wh, wv, 0, "R9");
        cycle(0, 0, 0, 32'h0, 24'h0, 0, 6, 7, wh, wv, 0, "R9");
        cycle(0, 0, 0, 32'h0, 24'h0, 0, 6, 7, wh, wv, 0, "R9");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule